// File: doc/BRIEF.md
# General-Purpose I/O Controller with Pin Interrupts

The block controls 32 general-purpose pins through eight 32-bit registers on a small memory-mapped register port. A direction bit selects for each pin whether it is driven or sensed. Driven pins take their value from a data register. Sensed pins pass through a synchronizer, and the synchronized level is what software reads back and what the interrupt logic evaluates.

Each sensed pin has a two-bit trigger mode: low level, high level, rising edge or falling edge. A separate any-edge register can override the mode of individual pins so that every level change triggers. Triggers set sticky status bits, and software clears them by writing ones. Status bits that are enabled in the mask drive the interrupt requests. A build parameter selects between one request covering all pins and two requests, one for pins 0–15 and one for pins 16–31. A second build parameter decides whether the any-edge register exists.

The register port uses a valid/ready request channel and a valid/ready response channel. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Each accepted request, read or write, returns exactly one response on the following edge. While a response is waiting with `rsp_ready` low, `req_ready` stays low and the response data holds.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset every register holds zero. All pins are inputs (`pin_oe` = 0), `pin_out` = 0 and both interrupt requests are low.
- R2: `pin_oe` equals the direction register, where bit value 1 means output. `pin_out` equals the data register. Both follow a write on the edge that accepts it.
- R3: Reading the data register (byte offset 0x00) returns the data bit for output pins and the synchronized pin level for input pins.
- R4: Reading the pad register (offset 0x08, read-only) returns the synchronized level ANDed with the inverse of direction. Writes to it have no effect.
- R5: The trigger mode of pin p is bits [2p+1:2p] of configuration-low (offset 0x0C) for p < 16, and bits [2(p-16)+1:2(p-16)] of configuration-high (offset 0x10) otherwise. Mode 00 sets status while the level is 0, and mode 01 sets it while the level is 1. The condition is evaluated on every cycle, so a bit cleared while its condition still holds sets again one cycle later.
- R6: Mode 10 sets status on a 0-to-1 change and mode 11 on a 1-to-0 change. A pin change that settles before an edge sets the status bit on the third clock edge, counting that edge as the first.
- R7: When built in, a 1 in the any-edge register (offset 0x1C) overrides the pin's mode, and every level change sets status. When it is not built in, the offset reads 0 and writes to it are ignored.
- R8: Pins whose direction bit is 1 never set status bits.
- R9: Status (offset 0x18) is write-one-to-clear. If a set and a clear of the same bit fall in one cycle, the bit ends up set. A new configuration takes effect from the cycle after the write is accepted.
- R10: With the split build, `irq[0]` is the OR of status AND mask (offset 0x14) over pins 0–15, and `irq[1]` is the same over pins 16–31. With the single build, `irq[0]` covers all pins and `irq[1]` is 0.
- R11: Only accesses with all four byte enables set and a word-aligned address inside 0x00–0x1C are performed. Any other write is ignored, and any other read returns 0.
- R12: `req_ready` is low exactly while a response is pending with `rsp_ready` low. A response appears on the edge after acceptance and holds its data until `rsp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_rdata | output | 32 | Read data, 0 for writes |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Pin drive values |
| pin_oe | output | 32 | Pin drive enables |
| irq | output | 2 | Interrupt requests |

## Verification
The two functions that can meet in one cycle are a trigger setting a status bit and a software write clearing that same bit. The bench provokes the meeting by toggling an any-edge pin and then issuing the clearing write after a delay that it sweeps across the synchronizer latency. At one of those delays the set and the clear land on the same edge. It also lets random pin activity overlap random status writes under response back-pressure. Each outcome is judged by reading status and watching the interrupt lines, compared against a cycle-level model built from the requirements, which expects the set to win.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned PIN_COUNT = 32;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned STRB_W    = WORD_W / 8;
  localparam int unsigned MODE_W    = 2;
  localparam int unsigned CFG_W     = PIN_COUNT * MODE_W;
  localparam int unsigned REG_COUNT = 8;
  localparam int unsigned IDX_W     = $clog2(REG_COUNT);
  localparam int unsigned IRQ_W     = 2;

  // Word index of each register; order defines the byte map.
  typedef enum logic [IDX_W-1:0] {
    REG_DATA   = 3'd0,
    REG_DIR    = 3'd1,
    REG_PAD    = 3'd2,
    REG_CFG_LO = 3'd3,
    REG_CFG_HI = 3'd4,
    REG_MASK   = 3'd5,
    REG_STAT   = 3'd6,
    REG_ANYE   = 3'd7
  } reg_sel_e;

  typedef enum logic [MODE_W-1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_mode_e;

  typedef struct packed {
    logic data;
    logic dir;
    logic cfg_lo;
    logic cfg_hi;
    logic mask;
    logic stat;
    logic any_edge;
  } reg_wr_t;
endpackage

// File: rtl/gpio_bus_port.sv
module gpio_bus_port
  import gpio_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  output logic                              req_ready,
  input  logic                              req_write,
  input  logic [ADDR_W-1:0]                 req_addr,
  input  logic [STRB_W-1:0]                 req_be,
  input  logic [WORD_W-1:0]                 req_wdata,
  output logic                              rsp_valid,
  input  logic                              rsp_ready,
  output logic [WORD_W-1:0]                 rsp_rdata,
  output reg_wr_t                           wr_en,
  output logic [WORD_W-1:0]                 wr_data,
  input  logic [REG_COUNT-1:0][WORD_W-1:0]  rd_bank
);
  localparam int unsigned OFS_LSB = $clog2(STRB_W);
  localparam int unsigned WIDX_W  = ADDR_W - OFS_LSB;

  logic              rsp_valid_q;
  logic [WORD_W-1:0] rsp_rdata_q;
  logic              accept;
  logic              aligned;
  logic              full_word;
  logic              in_map;
  logic              legal;
  logic [WIDX_W-1:0] word_idx;
  reg_sel_e          sel;

  assign word_idx  = req_addr[ADDR_W-1:OFS_LSB];
  assign sel       = reg_sel_e'(word_idx[IDX_W-1:0]);
  assign aligned   = ~|req_addr[OFS_LSB-1:0];
  assign full_word = &req_be;

  generate
    if (WIDX_W > IDX_W) begin : g_range
      assign in_map = ~|word_idx[WIDX_W-1:IDX_W];
    end else begin : g_exact
      assign in_map = 1'b1;
    end
  endgenerate

  assign legal     = aligned & full_word & in_map;
  assign req_ready = ~rsp_valid_q | rsp_ready;
  assign accept    = req_valid & req_ready;
  assign wr_data   = req_wdata;

  always_comb begin
    wr_en = '0;
    if (accept && req_write && legal) begin
      unique case (sel)
        REG_DATA:   wr_en.data     = 1'b1;
        REG_DIR:    wr_en.dir      = 1'b1;
        REG_CFG_LO: wr_en.cfg_lo   = 1'b1;
        REG_CFG_HI: wr_en.cfg_hi   = 1'b1;
        REG_MASK:   wr_en.mask     = 1'b1;
        REG_STAT:   wr_en.stat     = 1'b1;
        REG_ANYE:   wr_en.any_edge = 1'b1;
        default:    wr_en          = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_rdata_q <= (!req_write && legal) ? rd_bank[sel] : '0;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] level_prev
);
  logic [STAGES-1:0][WIDTH-1:0] chain;
  logic [WIDTH-1:0]             prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain[s] <= '0;
        end else begin
          chain[s] <= (s == 0) ? pin_in : chain[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= chain[STAGES-1];
    end
  end

  assign level      = chain[STAGES-1];
  assign level_prev = prev_q;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0]        level,
  input  logic [WIDTH-1:0]        level_prev,
  input  logic [WIDTH-1:0]        dir,
  input  logic [WIDTH*MODE_W-1:0] cfg,
  input  logic [WIDTH-1:0]        any_edge,
  output logic [WIDTH-1:0]        hit
);
  generate
    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
      trig_mode_e mode_p;
      logic       changed;
      logic       by_mode;

      assign mode_p  = trig_mode_e'(cfg[MODE_W*p +: MODE_W]);
      assign changed = level[p] ^ level_prev[p];

      always_comb begin
        unique case (mode_p)
          TRIG_LOW:  by_mode = ~level[p];
          TRIG_HIGH: by_mode = level[p];
          TRIG_RISE: by_mode = changed & level[p];
          TRIG_FALL: by_mode = changed & ~level[p];
          default:   by_mode = 1'b0;
        endcase
      end

      assign hit[p] = ~dir[p] & (any_edge[p] ? changed : by_mode);
    end
  endgenerate
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned ADDR_W       = 6,
  parameter bit          SPLIT_IRQ    = 1'b1,
  parameter bit          HAS_ANY_EDGE = 1'b1,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [STRB_W-1:0]    req_be,
  input  logic [WORD_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [WORD_W-1:0]    rsp_rdata,
  input  logic [PIN_COUNT-1:0] pin_in,
  output logic [PIN_COUNT-1:0] pin_out,
  output logic [PIN_COUNT-1:0] pin_oe,
  output logic [IRQ_W-1:0]     irq
);
  localparam int unsigned HALF = PIN_COUNT / 2;

  reg_wr_t                          wr_en;
  logic [WORD_W-1:0]                wr_data;
  logic [REG_COUNT-1:0][WORD_W-1:0] rd_bank;

  logic [PIN_COUNT-1:0] data_q;
  logic [PIN_COUNT-1:0] dir_q;
  logic [CFG_W-1:0]     cfg_q;
  logic [PIN_COUNT-1:0] mask_q;
  logic [PIN_COUNT-1:0] stat_q;
  logic [PIN_COUNT-1:0] anye_q;
  logic [PIN_COUNT-1:0] level;
  logic [PIN_COUNT-1:0] level_prev;
  logic [PIN_COUNT-1:0] hit;
  logic [PIN_COUNT-1:0] clr;
  logic [PIN_COUNT-1:0] pending;

  gpio_bus_port #(.ADDR_W(ADDR_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_bank   (rd_bank)
  );

  gpio_pin_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_in     (pin_in),
    .level      (level),
    .level_prev (level_prev)
  );

  gpio_trig_detect #(.WIDTH(PIN_COUNT)) u_detect (
    .level      (level),
    .level_prev (level_prev),
    .dir        (dir_q),
    .cfg        (cfg_q),
    .any_edge   (anye_q),
    .hit        (hit)
  );

  assign clr = wr_en.stat ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      cfg_q  <= '0;
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (wr_en.data)   data_q               <= wr_data;
      if (wr_en.dir)    dir_q                <= wr_data;
      if (wr_en.cfg_lo) cfg_q[WORD_W-1:0]    <= wr_data;
      if (wr_en.cfg_hi) cfg_q[CFG_W-1:WORD_W] <= wr_data;
      if (wr_en.mask)   mask_q               <= wr_data;
      // a trigger in the clearing cycle wins over the clear
      stat_q <= (stat_q & ~clr) | hit;
    end
  end

  generate
    if (HAS_ANY_EDGE) begin : g_anye
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          anye_q <= '0;
        end else if (wr_en.any_edge) begin
          anye_q <= wr_data;
        end
      end
    end else begin : g_no_anye
      logic unused_anye_wr;
      assign unused_anye_wr = wr_en.any_edge;
      assign anye_q         = '0;
    end
  endgenerate

  always_comb begin
    rd_bank             = '0;
    rd_bank[REG_DATA]   = (data_q & dir_q) | (level & ~dir_q);
    rd_bank[REG_DIR]    = dir_q;
    rd_bank[REG_PAD]    = level & ~dir_q;
    rd_bank[REG_CFG_LO] = cfg_q[WORD_W-1:0];
    rd_bank[REG_CFG_HI] = cfg_q[CFG_W-1:WORD_W];
    rd_bank[REG_MASK]   = mask_q;
    rd_bank[REG_STAT]   = stat_q;
    rd_bank[REG_ANYE]   = anye_q;
  end

  assign pending = stat_q & mask_q;

  generate
    if (SPLIT_IRQ) begin : g_split
      assign irq[0] = |pending[HALF-1:0];
      assign irq[1] = |pending[PIN_COUNT-1:HALF];
    end else begin : g_single
      assign irq[0] = |pending;
      assign irq[1] = 1'b0;
    end
  endgenerate

  assign pin_out = data_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
  import gpio_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_ready,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic [WORD_W-1:0]    rsp_rdata,
  input logic                 wr_dir,
  input logic [WORD_W-1:0]    wr_data,
  input logic [PIN_COUNT-1:0] stat_clr,
  input logic [PIN_COUNT-1:0] stat_q,
  input logic [PIN_COUNT-1:0] dir_q,
  input logic [PIN_COUNT-1:0] mask_q,
  input logic [PIN_COUNT-1:0] pin_oe,
  input logic [IRQ_W-1:0]     irq
);
  // R12
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R12
  stall_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R9
  stat_clear_by_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat_q) & ~stat_q & ~$past(stat_clr)) == '0));

  // R8
  output_pin_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & $past(dir_q)) == '0));

  // R2
  dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (pin_oe == $past(wr_data)));

  // R10
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> (irq == '0));
endmodule

bind gpio_ctrl gpio_ctrl_chk i_gpio_ctrl_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .wr_dir    (wr_en.dir),
  .wr_data   (wr_data),
  .stat_clr  ({gpio_pkg::WORD_W{wr_en.stat}} & wr_data),
  .stat_q    (stat_q),
  .dir_q     (dir_q),
  .mask_q    (mask_q),
  .pin_oe    (pin_oe),
  .irq       (irq)
);

// File: tb/gpio_ref.sv
module gpio_ref #(
  parameter bit SPLIT = 1'b1,
  parameter bit ANYE  = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] pins,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [5:0]  req_addr,
  input  logic [3:0]  req_be,
  input  logic [31:0] req_wdata,
  input  logic        rsp_ready,
  output logic        exp_req_ready,
  output logic        exp_rsp_valid,
  output logic [31:0] exp_rdata,
  output logic [31:0] exp_out,
  output logic [31:0] exp_oe,
  output logic [1:0]  exp_irq
);
  logic [31:0] s1, s2, pv, dat, dir, msk, st, ae;
  logic [63:0] cfg;
  logic        rv;
  logic [31:0] rd;

  function automatic logic pin_hit(logic cur, logic old, logic is_out,
                                   logic [1:0] mode, logic any);
    if (is_out) return 1'b0;
    if (any) return cur != old;
    case (mode)
      2'b00:   return cur == 1'b0;
      2'b01:   return cur == 1'b1;
      2'b10:   return !old && cur;
      default: return old && !cur;
    endcase
  endfunction

  function automatic logic [31:0] reg_value(logic [2:0] idx);
    case (idx)
      3'd0:    return (dat & dir) | (s2 & ~dir);
      3'd1:    return dir;
      3'd2:    return s2 & ~dir;
      3'd3:    return cfg[31:0];
      3'd4:    return cfg[63:32];
      3'd5:    return msk;
      3'd6:    return st;
      default: return ANYE ? ae : 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic        acc, ok;
    logic [31:0] hit, clr;
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; pv <= '0; dat <= '0; dir <= '0; msk <= '0;
      st <= '0; ae <= '0; cfg <= '0; rv <= 1'b0; rd <= '0;
    end else begin
      acc = req_valid && (!rv || rsp_ready);
      ok  = (req_be == 4'hF) && (req_addr[1:0] == 2'b00) && !req_addr[5];
      for (int i = 0; i < 32; i++)
        hit[i] = pin_hit(s2[i], pv[i], dir[i], cfg[2*i +: 2], ae[i]);
      clr = (acc && req_write && ok && req_addr[4:2] == 3'd6) ? req_wdata : 32'h0;
      st <= (st & ~clr) | hit;
      s1 <= pins; s2 <= s1; pv <= s2;
      if (acc && req_write && ok) begin
        case (req_addr[4:2])
          3'd0: dat <= req_wdata;
          3'd1: dir <= req_wdata;
          3'd3: cfg[31:0] <= req_wdata;
          3'd4: cfg[63:32] <= req_wdata;
          3'd5: msk <= req_wdata;
          3'd7: if (ANYE) ae <= req_wdata;
          default: ;
        endcase
      end
      if (acc) begin
        rv <= 1'b1;
        rd <= (!req_write && ok) ? reg_value(req_addr[4:2]) : 32'h0;
      end else if (rsp_ready) begin
        rv <= 1'b0;
      end
    end
  end

  assign exp_req_ready = !rv || rsp_ready;
  assign exp_rsp_valid = rv;
  assign exp_rdata     = rd;
  assign exp_out       = dat;
  assign exp_oe        = dir;
  assign exp_irq       = SPLIT ? {|(st & msk & 32'hFFFF0000), |(st & msk & 32'h0000FFFF)}
                               : {1'b0, |(st & msk)};
endmodule

// File: tb/test_gpio_ctrl.sv
module test_gpio_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [5:0]  req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_ready = 1'b1;
  logic [31:0] pins = '0;

  logic        rdy_a, rv_a, rdy_b, rv_b;
  logic [31:0] rd_a, out_a, oe_a, rd_b, out_b, oe_b;
  logic [1:0]  irq_a, irq_b;

  logic        e_rdy_a, e_rv_a, e_rdy_b, e_rv_b;
  logic [31:0] e_rd_a, e_out_a, e_oe_a, e_rd_b, e_out_b, e_oe_b;
  logic [1:0]  e_irq_a, e_irq_b;

  int    vectors = 0, fails = 0, cyc = 0;
  bit    done = 1'b0, force_stall = 1'b0, rand_bp = 1'b0, rand_pins = 1'b0;
  string cur_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_ctrl i_gpio_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_a),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rv_a), .rsp_ready(rsp_ready),
    .rsp_rdata(rd_a), .pin_in(pins), .pin_out(out_a), .pin_oe(oe_a), .irq(irq_a));

  gpio_ctrl #(.SPLIT_IRQ(1'b0), .HAS_ANY_EDGE(1'b0)) i_gpio_ctrl_flat (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_b),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rv_b), .rsp_ready(rsp_ready),
    .rsp_rdata(rd_b), .pin_in(pins), .pin_out(out_b), .pin_oe(oe_b), .irq(irq_b));

  gpio_ref #(.SPLIT(1'b1), .ANYE(1'b1)) i_ref_a (
    .clk(clk), .rst_n(rst_n), .pins(pins), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_ready(rsp_ready), .exp_req_ready(e_rdy_a),
    .exp_rsp_valid(e_rv_a), .exp_rdata(e_rd_a), .exp_out(e_out_a),
    .exp_oe(e_oe_a), .exp_irq(e_irq_a));

  gpio_ref #(.SPLIT(1'b0), .ANYE(1'b0)) i_ref_b (
    .clk(clk), .rst_n(rst_n), .pins(pins), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_ready(rsp_ready), .exp_req_ready(e_rdy_b),
    .exp_rsp_valid(e_rv_b), .exp_rdata(e_rd_b), .exp_out(e_out_b),
    .exp_oe(e_oe_b), .exp_irq(e_irq_b));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  // compare both builds against their models just before each falling edge
  always @(posedge clk) begin
    #(CLK_PERIOD/2 - 2);
    if (rst_n && !done) begin
      check("R12 req_ready split", {31'b0, rdy_a}, {31'b0, e_rdy_a});
      check("R12 rsp_valid split", {31'b0, rv_a}, {31'b0, e_rv_a});
      if (e_rv_a) check({cur_tag, " rdata split"}, rd_a, e_rd_a);
      check("R10 irq split", {30'b0, irq_a}, {30'b0, e_irq_a});
      check("R2 pin_out", out_a, e_out_a);
      check("R2 pin_oe", oe_a, e_oe_a);
      check("R12 req_ready single", {31'b0, rdy_b}, {31'b0, e_rdy_b});
      check("R12 rsp_valid single", {31'b0, rv_b}, {31'b0, e_rv_b});
      if (e_rv_b) check({cur_tag, " rdata single"}, rd_b, e_rd_b);
      check("R10 irq single", {30'b0, irq_b}, {30'b0, e_irq_b});
      check("R2 pin_oe single", oe_b, e_oe_b);
    end
  end

  always @(negedge clk) begin
    if (force_stall)  rsp_ready = 1'b0;
    else if (rand_bp) rsp_ready = ($urandom % 4) != 0;
    else              rsp_ready = 1'b1;
    if (rand_pins) pins = pins ^ ($urandom & $urandom & $urandom & $urandom);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      fails++;
      $display("FAIL R12 watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      report();
    end
  end

  task automatic access(bit wr, logic [5:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    forever begin
      #1;
      if (rdy_a) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    access(1'b1, a, d, 4'hF);
  endtask

  task automatic rd(logic [5:0] a);
    access(1'b0, a, 32'h0, 4'hF);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_61a0));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state at the ports
    check("R1 pin_oe", oe_a, 32'h0);
    check("R1 pin_out", out_a, 32'h0);
    check("R1 irq", {30'b0, irq_a}, 32'h0);
    for (int r = 0; r < 8; r++) rd(6'(r * 4));

    // R2, R3, R4: drive and read back
    cur_tag = "R2";
    wr(6'h04, 32'hFFFF_0000);
    wr(6'h00, 32'hA5A5_5A5A);
    wait_cyc(1); #1;
    check("R2 pin_oe after write", oe_a, 32'hFFFF_0000);
    check("R2 pin_out after write", out_a, 32'hA5A5_5A5A);
    pins = 32'h1234_5678;
    wait_cyc(4);
    cur_tag = "R3"; rd(6'h00);
    cur_tag = "R4"; rd(6'h08); wr(6'h08, 32'hFFFF_FFFF); rd(6'h08);

    // R5: level modes, re-set after clear
    cur_tag = "R5";
    pins = 32'h0;
    wr(6'h04, 32'h0);
    wr(6'h0C, 32'h0000_0001);
    wr(6'h14, 32'h0000_0001);
    wr(6'h18, 32'hFFFF_FFFF);
    pins[0] = 1'b1;
    wait_cyc(4); #1;
    check("R5 irq on high level", {31'b0, irq_a[0]}, 32'h1);
    rd(6'h18); wr(6'h18, 32'h1); rd(6'h18);
    pins[0] = 1'b0;
    wait_cyc(4); wr(6'h18, 32'h1); rd(6'h18);

    // R6: rising on pin 1, falling on pin 2
    cur_tag = "R6";
    wr(6'h0C, 32'h0000_0039);
    wr(6'h18, 32'hFFFF_FFFF);
    pins[1] = 1'b1; wait_cyc(5); rd(6'h18); wr(6'h18, 32'hFFFF_FFFF);
    pins[2] = 1'b1; wait_cyc(5); rd(6'h18); wr(6'h18, 32'hFFFF_FFFF);
    pins[2] = 1'b0; wait_cyc(5); rd(6'h18); wr(6'h18, 32'hFFFF_FFFF);
    pins[1] = 1'b0; wait_cyc(5); rd(6'h18);

    // R7: any-edge override on pin 3
    cur_tag = "R7";
    wr(6'h1C, 32'h0000_0008);
    wr(6'h18, 32'hFFFF_FFFF);
    pins[3] = 1'b1; wait_cyc(5); rd(6'h18); wr(6'h18, 32'hFFFF_FFFF);
    pins[3] = 1'b0; wait_cyc(5); rd(6'h18); rd(6'h1C);

    // R8: an output pin with a satisfied level mode stays clear
    cur_tag = "R8";
    wr(6'h04, 32'h0000_0010);
    wr(6'h0C, 32'h0000_0139);
    pins[4] = 1'b1;
    wr(6'h18, 32'hFFFF_FFFF);
    wait_cyc(5); rd(6'h18);

    // R9: sweep the clear against an any-edge set on pin 5
    cur_tag = "R9";
    wr(6'h1C, 32'h0000_0020);
    wr(6'h14, 32'h0000_0020);
    for (int off = 0; off < 6; off++) begin
      wr(6'h18, 32'hFFFF_FFFF);
      pins[5] = ~pins[5];
      wait_cyc(off);
      wr(6'h18, 32'h0000_0020);
      wait_cyc(4);
      rd(6'h18);
    end

    // R10: split against single request
    cur_tag = "R10";
    wr(6'h14, 32'h0001_0000);
    wr(6'h10, 32'h0000_0001);
    pins[16] = 1'b1;
    wait_cyc(5); #1;
    check("R10 split upper only", {30'b0, irq_a}, 32'h2);
    check("R10 single request", {30'b0, irq_b}, 32'h1);
    wr(6'h14, 32'h0001_0001);
    pins[0] = 1'b1;
    wait_cyc(5); #1;
    check("R10 split both", {30'b0, irq_a}, 32'h3);

    // R11: partial, misaligned and unmapped accesses
    cur_tag = "R11";
    access(1'b1, 6'h14, 32'hFFFF_FFFF, 4'h3);
    access(1'b0, 6'h14, 32'h0, 4'h3);
    rd(6'h14);
    access(1'b1, 6'h16, 32'h0, 4'hF);
    rd(6'h16); rd(6'h20); wr(6'h24, 32'hDEAD_BEEF); rd(6'h3C); rd(6'h14);

    // R12: response back-pressure
    cur_tag = "R12";
    force_stall = 1'b1;
    fork
      begin rd(6'h14); rd(6'h04); end
    join_none
    wait_cyc(6);
    force_stall = 1'b0;
    wait_cyc(6);

    // random mix
    cur_tag = "R5/R6/R7/R8/R9/R11 random";
    rand_bp = 1'b1; rand_pins = 1'b1;
    for (int n = 0; n < 3000; n++) begin
      logic [5:0]  a;
      logic [3:0]  be;
      a  = (($urandom % 10) != 0) ? 6'(($urandom % 8) * 4) : 6'($urandom);
      be = (($urandom % 10) != 0) ? 4'hF : 4'($urandom);
      access(($urandom % 2) == 1, a, $urandom, be);
      if (($urandom % 4) == 0) wait_cyc($urandom % 4);
    end
    rand_bp = 1'b0; rand_pins = 1'b0;
    wait_cyc(8);
    report();
  end
endmodule